// File: doc/BRIEF.md
# Flash Erase and Write Sequencer

This block sequences timed erase and program operations on an on-chip program flash. Software loads a command register (operation code, byte address, data byte) and then pulses a start strobe. A down-counting timer holds the block busy for the programming or erase time. The array is changed on the last busy cycle. Erases work on three aligned region sizes: a 32-byte page, a 256-byte block, or the whole array. A programmed byte can only lose ones, so a write takes effect as a bitwise AND of the new data into the stored byte. An erased byte reads 0xFF.

Verification is a separate command. It compares one stored byte with the data byte in a single cycle and does not start the timer. A start that arrives while an operation runs is rejected and sets a sticky error flag. An array read made while busy returns 0xFF and flags a collision. The flash cells are modelled by a plain register array. The default depth of 2 Kbytes keeps elaboration small, and ADDR_W = 15 gives the full 32 Kbyte map, whose top byte at 0x7FFF holds the security setting. Tick counts are parameters, so simulation can use short durations.

Top module: `flash_seq`

## Requirements
- R1: After a synchronous active-low reset, busy, start_err, verify_pass and rd_collide are 0 and rd_data is 0xFF.
- R2: Operation code 1 (byte write): a start while idle holds busy high for exactly WRITE_TICKS cycles after the start edge, and the addressed byte then becomes its old value ANDed with the data byte.
- R3: Operation code 2 (page erase): busy is high for ERASE_TICKS cycles, and afterwards every byte whose address matches the command address with its low 5 bits ignored reads 0xFF; bytes outside that page keep their values.
- R4: Operation code 3 (block erase): the same as R3 with the low 8 bits ignored (an aligned 256-byte region).
- R5: Operation code 4 (full erase): busy is high for ERASE_TICKS cycles, and afterwards every byte, including the top address, reads 0xFF.
- R6: Operation code 5 (verify): at the start edge, verify_pass takes 1 if the stored byte at the command address equals the data byte and 0 otherwise; busy stays 0.
- R7: A start while busy is ignored and sets start_err; the running operation completes with the address, data and code latched at its own start.
- R8: A command register write (cmd_we) clears start_err. If a write coincides with a rejected start, start_err is set.
- R9: A read (rd_en) sampled while busy returns rd_data 0xFF with rd_collide 1 on the next cycle; a read sampled while idle returns the stored byte with rd_collide 0.
- R10: Operation codes 0, 6 and 7 start nothing: busy stays 0 and the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Load command register |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_data | input | 8 | Data byte for write or verify |
| start | input | 1 | Start the registered command |
| busy | output | 1 | Timed operation in progress |
| start_err | output | 1 | Sticky rejected-start flag |
| verify_pass | output | 1 | Result of the last verify |
| rd_en | input | 1 | Array read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data, one cycle after rd_en |
| rd_collide | output | 1 | Read was made while busy |

## Verification
Two events can fall in the same cycle: a start rejected because busy is high, and a command register write. The bench drives cmd_we and start at the same edge during an erase. It expects start_err to be 1 afterwards, and expects the erase to finish with its own latched region even though the command register now holds other values. A second collision is an array read made during the last busy cycle, when the array is being committed. That read must still return 0xFF with rd_collide set, and a read one cycle later must see the erased contents.

// File: rtl/flash_seq_pkg.sv
// Shared operation codes for the flash sequencer.
// Assumes a 3-bit command field; unlisted codes act as no-ops.
package flash_seq_pkg;
    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_WRITE  = 3'd1,
        OP_PAGE   = 3'd2,
        OP_BLOCK  = 3'd3,
        OP_FULL   = 3'd4,
        OP_VERIFY = 3'd5
    } op_e;
endpackage

// File: rtl/flash_seq_timer.sv
// Duration timer: loads a tick count on launch and counts down to zero.
// Assumes both tick counts are at least 1; finish pulses in the final busy cycle.
module flash_seq_timer #(
    parameter int WRITE_TICKS = 125000,
    parameter int ERASE_TICKS = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic long_op,
    output logic busy,
    output logic finish
);
    localparam int MAXT = (WRITE_TICKS > ERASE_TICKS) ? WRITE_TICKS : ERASE_TICKS;
    localparam int CW   = $clog2(MAXT + 1);

    logic [CW-1:0] cnt;

    // Load on launch, otherwise count down while nonzero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (launch)
            cnt <= long_op ? CW'(ERASE_TICKS) : CW'(WRITE_TICKS);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy   = (cnt != '0);
    assign finish = (cnt == CW'(1));
endmodule

// File: rtl/flash_seq_ctrl.sv
// Command register, start arbitration, sticky error and verify result.
// Assumes start uses register contents from before the current edge.
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              start,
    input  logic              busy,
    input  logic [7:0]        peek_byte,
    output logic [ADDR_W-1:0] peek_addr,
    output op_e               act_op,
    output logic [ADDR_W-1:0] act_addr,
    output logic [7:0]        act_data,
    output logic              launch,
    output logic              long_op,
    output logic              start_err,
    output logic              verify_pass
);
    op_e               reg_op;
    logic [ADDR_W-1:0] reg_addr;
    logic [7:0]        reg_data;
    logic              timed;

    // Decide whether the registered code needs the timer.
    always_comb begin
        timed = (reg_op == OP_WRITE) || (reg_op == OP_PAGE) ||
                (reg_op == OP_BLOCK) || (reg_op == OP_FULL);
    end

    assign launch    = start && !busy && timed;
    assign long_op   = (reg_op != OP_WRITE);
    assign peek_addr = reg_addr;

    // Register the command, latch the active operation, track error and verify.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_op      <= OP_NOP;
            reg_addr    <= '0;
            reg_data    <= '0;
            act_op      <= OP_NOP;
            act_addr    <= '0;
            act_data    <= '0;
            start_err   <= 1'b0;
            verify_pass <= 1'b0;
        end else begin
            if (cmd_we) begin
                reg_op   <= op_e'(cmd_op);
                reg_addr <= cmd_addr;
                reg_data <= cmd_data;
            end
            if (launch) begin
                act_op   <= reg_op;
                act_addr <= reg_addr;
                act_data <= reg_data;
            end
            if (start && busy)
                start_err <= 1'b1;
            else if (cmd_we)
                start_err <= 1'b0;
            if (start && !busy && reg_op == OP_VERIFY)
                verify_pass <= (peek_byte == reg_data);
        end
    end
endmodule

// File: rtl/flash_seq_array.sv
// Register model of the flash cells with an erase-region decoder and read port.
// Assumes ADDR_W > BLOCK_BITS; cells have no reset, like real flash.
module flash_seq_array
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BITS  = 5,
    parameter int BLOCK_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  op_e               act_op,
    input  logic [ADDR_W-1:0] act_addr,
    input  logic [7:0]        act_data,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [7:0]        peek_byte,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              busy,
    output logic [7:0]        rd_data,
    output logic              rd_collide
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] PAGE_KEEP  = {{(ADDR_W-PAGE_BITS){1'b1}},  {PAGE_BITS{1'b0}}};
    localparam logic [ADDR_W-1:0] BLOCK_KEEP = {{(ADDR_W-BLOCK_BITS){1'b1}}, {BLOCK_BITS{1'b0}}};

    logic [7:0]        mem [DEPTH];
    logic [ADDR_W-1:0] keep_mask;

    // Select which address bits identify the erase region.
    always_comb begin
        case (act_op)
            OP_PAGE:  keep_mask = PAGE_KEEP;
            OP_BLOCK: keep_mask = BLOCK_KEEP;
            default:  keep_mask = '0;
        endcase
    end

    assign peek_byte = mem[peek_addr];

    // Apply the finished write or erase to the cells.
    always_ff @(posedge clk) begin
        if (commit) begin
            if (act_op == OP_WRITE)
                mem[act_addr] <= mem[act_addr] & act_data;
            else
                for (int i = 0; i < DEPTH; i++)
                    if ((ADDR_W'(i) & keep_mask) == (act_addr & keep_mask))
                        mem[i] <= 8'hFF;
        end
    end

    // Serve array reads, blocked while an operation runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data    <= 8'hFF;
            rd_collide <= 1'b0;
        end else if (rd_en) begin
            rd_data    <= busy ? 8'hFF : mem[rd_addr];
            rd_collide <= busy;
        end else begin
            rd_collide <= 1'b0;
        end
    end
endmodule

// File: rtl/flash_seq.sv
// Top of the flash erase and write sequencer.
// Assumes the command register is loaded before start is pulsed.
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_BITS   = 5,
    parameter int BLOCK_BITS  = 8,
    parameter int WRITE_TICKS = 125000,
    parameter int ERASE_TICKS = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              start,
    output logic              busy,
    output logic              start_err,
    output logic              verify_pass,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              rd_collide
);
    logic              launch, long_op, finish;
    op_e               act_op;
    logic [ADDR_W-1:0] act_addr, peek_addr;
    logic [7:0]        act_data, peek_byte;

    flash_seq_timer #(.WRITE_TICKS(WRITE_TICKS), .ERASE_TICKS(ERASE_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .launch(launch), .long_op(long_op),
        .busy(busy), .finish(finish)
    );

    flash_seq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .start(start), .busy(busy),
        .peek_byte(peek_byte), .peek_addr(peek_addr), .act_op(act_op),
        .act_addr(act_addr), .act_data(act_data), .launch(launch),
        .long_op(long_op), .start_err(start_err), .verify_pass(verify_pass)
    );

    flash_seq_array #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .BLOCK_BITS(BLOCK_BITS)) u_array (
        .clk(clk), .rst_n(rst_n), .commit(finish), .act_op(act_op),
        .act_addr(act_addr), .act_data(act_data), .peek_addr(peek_addr),
        .peek_byte(peek_byte), .rd_en(rd_en), .rd_addr(rd_addr), .busy(busy),
        .rd_data(rd_data), .rd_collide(rd_collide)
    );
endmodule

// File: rtl/flash_seq_chk.sv
// Property checker for the sequencer, attached by bind below.
// Assumes only the top-level ports are visible.
module flash_seq_chk #(
    parameter int WRITE_TICKS = 125000,
    parameter int ERASE_TICKS = 250000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_we,
    input logic       start,
    input logic       busy,
    input logic       start_err,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic       rd_collide
);
    localparam int MAXT = (WRITE_TICKS > ERASE_TICKS) ? WRITE_TICKS : ERASE_TICKS;

    int run_len;

    // Count consecutive busy cycles to bound the operation length.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    p_busy_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < MAXT));
    p_reject_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> start_err);
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_err && !cmd_we) |=> start_err);
    p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !(start && busy)) |=> !start_err);
    p_busy_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> (rd_collide && rd_data == 8'hFF));
    p_idle_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !busy) |=> !rd_collide);
endmodule

bind flash_seq flash_seq_chk #(.WRITE_TICKS(WRITE_TICKS), .ERASE_TICKS(ERASE_TICKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .start(start), .busy(busy),
    .start_err(start_err), .rd_en(rd_en), .rd_data(rd_data), .rd_collide(rd_collide)
);

// File: tb/tb_flash_seq.sv
module tb_flash_seq;
    localparam int AW = 11;
    localparam int WT = 6;
    localparam int ET = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_we = 1'b0, start = 1'b0, rd_en = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0, rd_addr = '0;
    logic [7:0]    cmd_data = '0, rd_data;
    logic          busy, start_err, verify_pass, rd_collide;

    int  n_chk = 0, n_fail = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    flash_seq #(.ADDR_W(AW), .WRITE_TICKS(WT), .ERASE_TICKS(ET)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .start(start), .busy(busy),
        .start_err(start_err), .verify_pass(verify_pass), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_collide(rd_collide)
    );

    typedef struct packed {
        logic [2:0]    op;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic [AW-1:0] chk;
        logic [7:0]    exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TAB [NV] = '{
        '{3'd4, 11'h000, 8'h00, 11'h123, 8'hFF},
        '{3'd1, 11'h123, 8'h5A, 11'h123, 8'h5A},
        '{3'd1, 11'h123, 8'h0F, 11'h123, 8'h0A},
        '{3'd1, 11'h140, 8'h33, 11'h140, 8'h33},
        '{3'd1, 11'h11F, 8'h77, 11'h11F, 8'h77},
        '{3'd2, 11'h12F, 8'h00, 11'h123, 8'hFF},
        '{3'd0, 11'h000, 8'h00, 11'h140, 8'h33},
        '{3'd0, 11'h000, 8'h00, 11'h11F, 8'h77},
        '{3'd1, 11'h7FF, 8'h11, 11'h7FF, 8'h11},
        '{3'd1, 11'h200, 8'h44, 11'h200, 8'h44},
        '{3'd3, 11'h2AB, 8'h00, 11'h200, 8'hFF},
        '{3'd0, 11'h000, 8'h00, 11'h7FF, 8'h11}
    };

    function automatic string tag_of(logic [2:0] op);
        case (op)
            3'd1:    return "R2";
            3'd2:    return "R3";
            3'd3:    return "R4";
            3'd4:    return "R5";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(logic [2:0] op, logic [AW-1:0] a, logic [7:0] d);
        @(negedge clk);
        cmd_we = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    // Pulse start and return the number of busy cycles seen afterwards.
    task automatic go(output int n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic rd(logic [AW-1:0] a);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 start_err", start_err, 0);
        check("R1 verify_pass", verify_pass, 0);
        check("R1 rd_collide", rd_collide, 0);
        check("R1 rd_data", rd_data, 8'hFF);
        rst_n = 1'b1;

        // Table walk: each operation, then a readback.
        for (int i = 0; i < NV; i++) begin
            load(TAB[i].op, TAB[i].addr, TAB[i].data);
            go(n);
            if (TAB[i].op == 3'd1)      check("R2 busy length", n, WT);
            else if (TAB[i].op == 3'd0) check("R10 no busy", n, 0);
            else                        check({tag_of(TAB[i].op), " busy length"}, n, ET);
            rd(TAB[i].chk);
            check({tag_of(TAB[i].op), " readback"}, rd_data, TAB[i].exp);
            check("R9 idle read no collide", rd_collide, 0);
        end

        // R4: block erase left the neighbouring block intact.
        rd(11'h140);
        check("R4 outside block", rd_data, 8'h33);

        // R6: verify pass and fail, no busy.
        load(3'd5, 11'h140, 8'h33);
        go(n);
        check("R6 verify match", verify_pass, 1);
        check("R6 no busy", n, 0);
        load(3'd5, 11'h140, 8'h34);
        go(n);
        check("R6 verify mismatch", verify_pass, 0);

        // R10: unused code 6 writes nothing.
        load(3'd6, 11'h140, 8'h00);
        go(n);
        check("R10 code 6 no busy", n, 0);
        rd(11'h140);
        check("R10 code 6 array unchanged", rd_data, 8'h33);

        // R7, R8, R9: page erase with a rejected start, a same-cycle write and busy reads.
        load(3'd2, 11'h150, 8'h00);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R7 erase running", busy, 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R7 rejected start flags", start_err, 1);
        cmd_we = 1'b1; cmd_op = 3'd1; cmd_addr = 11'h7FF; cmd_data = 8'h00; start = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0; start = 1'b0;
        check("R8 same-cycle write and reject", start_err, 1);
        rd(11'h7FF);
        check("R9 busy read data", rd_data, 8'hFF);
        check("R9 busy read collide", rd_collide, 1);
        while (busy) @(negedge clk);
        rd(11'h140);
        check("R7 latched page erased", rd_data, 8'hFF);
        rd(11'h7FF);
        check("R7 new command not run", rd_data, 8'h11);
        check("R7 error sticky", start_err, 1);
        load(3'd0, 11'h000, 8'h00);
        check("R8 write clears error", start_err, 0);

        // R9: read in the last busy cycle (commit edge), then the next cycle.
        load(3'd4, 11'h000, 8'h00);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (ET - 1) @(negedge clk);
        check("R5 still busy at last tick", busy, 1);
        rd(11'h7FF);
        check("R9 commit-cycle read collide", rd_collide, 1);
        check("R9 commit-cycle read data", rd_data, 8'hFF);
        check("R5 idle after erase", busy, 0);
        rd(11'h7FF);
        check("R5 top byte erased", rd_data, 8'hFF);
        check("R9 idle read after commit", rd_collide, 0);

        finish_run();
    end
endmodule